// File: doc/BRIEF.md
# Device Power-State Sequencer

This block follows the power state of a network function through four states: held in reset, running but not yet set up by its driver, fully active, and a low-power sleep state. An internal power-on reset forces it into the reset state at once. From then on it is moved by the platform's active-low reset line, a driver-ready indication and a sleep request. The platform reset line crosses into the block's clock domain through a two-flop synchronizer. Its deassertion is then found with an edge detector.

Besides the state itself, the block drives three control outputs. A hold line tells the wake-filter registers to keep their contents while the function is in reset. An enable line keeps the sideband management clock running during reset when configuration asks for it. A deep-idle flag shows that nothing needs to stay alive, because the function is in reset and no function has wake-on-LAN active. All pins are plain level signals. No data flows through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `pwr_state_seq`

## Requirements
- R1: While `por_i` is high, `state_o` is 2'b00 (reset state) at once, without waiting for a clock edge, and `wake_hold_o` is 1.
- R2: In the reset state, a low-to-high change of `plat_rst_n_i` moves `state_o` to 2'b01 (uninitialized) on the third rising clock edge after the change. This includes the case where the line is already high when `por_i` is released.
- R3: When `plat_rst_n_i` goes low while `state_o` is 2'b01, 2'b10 or 2'b11, `state_o` becomes 2'b00 on the third rising clock edge after the change.
- R4: The reset state has no timeout. While `plat_rst_n_i` stays low, `state_o` stays 2'b00 however long that lasts, and `drv_init_i` and `d3_req_i` have no effect.
- R5: In state 2'b01, `drv_init_i` high moves the state to 2'b10 (active) on the next edge, and `d3_req_i` is ignored. In state 2'b10, `d3_req_i` high moves the state to 2'b11 (sleep) on the next edge. State 2'b11 ignores both inputs.
- R6: `wake_hold_o` is 1 exactly while `state_o` is 2'b00.
- R7: `sb_clk_en_o` is 1 in states 2'b01, 2'b10 and 2'b11. In state 2'b00 it equals `sb_clk_cfg_i`.
- R8: `deep_idle_o` is 1 exactly when `state_o` is 2'b00 and every bit of `wake_act_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| por_i | input | 1 | Internal power-on reset, active high, asynchronous |
| plat_rst_n_i | input | 1 | Platform reset, active low, asynchronous to `clk_i` |
| drv_init_i | input | 1 | Driver has finished setting up the function |
| d3_req_i | input | 1 | Request to enter the sleep state |
| wake_act_i | input | NUM_FUNC | Wake-on-LAN active, one bit per function |
| sb_clk_cfg_i | input | 1 | Configuration: keep the sideband clock running in reset |
| state_o | output | 2 | Current state: 00 reset, 01 uninitialized, 10 active, 11 sleep |
| deep_idle_o | output | 1 | Reset state with no wake source active |
| sb_clk_en_o | output | 1 | Sideband management clock enable |
| wake_hold_o | output | 1 | Keep the wake-filter settings intact |

## Verification
A change on `plat_rst_n_i` reaches `state_o` on the third rising edge after it: two synchronizer flops, then the state register. `drv_init_i` and `d3_req_i` take effect on the next edge. The three control outputs are decoded without registers from the state and the current inputs, so they follow in the same cycle. `por_i` acts at once. The bench drives inputs on the falling edge and waits an exact number of rising edges per vector. Some vectors stop one edge short of a transition, to show the state has not moved yet. All values are sampled on the following falling edge.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    ST_RESET  = 2'b00,
    ST_UNINIT = 2'b01,
    ST_ACTIVE = 2'b10,
    ST_SLEEP  = 2'b11
  } pwr_st_e;
endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic async_n_i,
  output logic level_o,
  output logic rise_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic          prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) chain_q <= '0;
        else       chain_q <= async_n_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) chain_q <= '0;
        else       chain_q <= {chain_q[LAST-1:0], async_n_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) prev_q <= 1'b0;
    else       prev_q <= chain_q[LAST];
  end

  assign level_o = chain_q[LAST];
  assign rise_o  = chain_q[LAST] & ~prev_q;

  // R2: the release is seen as a single-cycle pulse
  p_rise_single_r2: assert property (@(posedge clk_i) disable iff (por_i)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    por_i,
  input  logic    lvl_i,
  input  logic    rise_i,
  input  logic    drv_init_i,
  input  logic    d3_req_i,
  output pwr_st_e st_o
);
  pwr_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (st_q != ST_RESET && !lvl_i) begin
      st_d = ST_RESET;
    end else begin
      unique case (st_q)
        ST_RESET:  if (rise_i)     st_d = ST_UNINIT;
        ST_UNINIT: if (drv_init_i) st_d = ST_ACTIVE;
        ST_ACTIVE: if (d3_req_i)   st_d = ST_SLEEP;
        ST_SLEEP:  st_d = ST_SLEEP;
        default:   st_d = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) st_q <= ST_RESET;
    else       st_q <= st_d;
  end

  assign st_o = st_q;

  p_release_leaves_reset_r2: assert property (@(posedge clk_i) disable iff (por_i)
    (st_q == ST_RESET && rise_i) |=> st_q == ST_UNINIT);
  p_assert_enters_reset_r3: assert property (@(posedge clk_i) disable iff (por_i)
    (st_q != ST_RESET && !lvl_i) |=> st_q == ST_RESET);
  p_no_timeout_r4: assert property (@(posedge clk_i) disable iff (por_i)
    (st_q == ST_RESET && !lvl_i) |=> st_q == ST_RESET);
  p_sleep_entry_r5: assert property (@(posedge clk_i) disable iff (por_i)
    (st_q == ST_ACTIVE && lvl_i && d3_req_i) |=> st_q == ST_SLEEP);
endmodule

// File: rtl/pwr_out_decode.sv
module pwr_out_decode
  import pwr_seq_pkg::*;
#(
  parameter int NUM_FUNC = 2
) (
  input  logic                clk_i,
  input  logic                por_i,
  input  pwr_st_e             st_i,
  input  logic [NUM_FUNC-1:0] wake_i,
  input  logic                clk_cfg_i,
  output logic                idle_o,
  output logic                clk_en_o,
  output logic                hold_o
);
  logic in_reset;
  logic any_wake;

  assign in_reset = (st_i == ST_RESET);
  assign any_wake = |wake_i;

  assign hold_o   = in_reset;
  assign clk_en_o = in_reset ? clk_cfg_i : 1'b1;
  assign idle_o   = in_reset & ~any_wake;

  // R8: deep idle never coexists with an active wake source
  p_idle_no_wake_r8: assert property (@(posedge clk_i) disable iff (por_i)
    idle_o |-> (wake_i == '0));
  // R7: clock may only stop in the reset state
  p_clk_stop_reset_r7: assert property (@(posedge clk_i) disable iff (por_i)
    !clk_en_o |-> (st_i == ST_RESET && !clk_cfg_i));
endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
  import pwr_seq_pkg::*;
#(
  parameter int NUM_FUNC    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                por_i,
  input  logic                plat_rst_n_i,
  input  logic                drv_init_i,
  input  logic                d3_req_i,
  input  logic [NUM_FUNC-1:0] wake_act_i,
  input  logic                sb_clk_cfg_i,
  output logic [1:0]          state_o,
  output logic                deep_idle_o,
  output logic                sb_clk_en_o,
  output logic                wake_hold_o
);
  logic    rst_lvl;
  logic    rst_rise;
  pwr_st_e st;

  pwr_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .por_i     (por_i),
    .async_n_i (plat_rst_n_i),
    .level_o   (rst_lvl),
    .rise_o    (rst_rise)
  );

  pwr_state_fsm u_fsm (
    .clk_i      (clk_i),
    .por_i      (por_i),
    .lvl_i      (rst_lvl),
    .rise_i     (rst_rise),
    .drv_init_i (drv_init_i),
    .d3_req_i   (d3_req_i),
    .st_o       (st)
  );

  pwr_out_decode #(.NUM_FUNC(NUM_FUNC)) u_dec (
    .clk_i     (clk_i),
    .por_i     (por_i),
    .st_i      (st),
    .wake_i    (wake_act_i),
    .clk_cfg_i (sb_clk_cfg_i),
    .idle_o    (deep_idle_o),
    .clk_en_o  (sb_clk_en_o),
    .hold_o    (wake_hold_o)
  );

  assign state_o = st;

  // R2: the uninitialized state is only ever entered from reset
  p_uninit_origin_r2: assert property (@(posedge clk_i) disable iff (por_i)
    (state_o != 2'b01) |=> (state_o != 2'b01 || $past(state_o) == 2'b00));
  // R5: sleep is only ever entered from active
  p_sleep_origin_r5: assert property (@(posedge clk_i) disable iff (por_i)
    (state_o != 2'b11) |=> (state_o != 2'b11 || $past(state_o) == 2'b10));
  // R6: hold rises only together with entry to reset
  p_hold_entry_r6: assert property (@(posedge clk_i) disable iff (por_i)
    $rose(wake_hold_o) |-> (state_o == 2'b00 && $past(state_o) != 2'b00));
endmodule

// File: tb/sim_pwr_state_seq.sv
module sim_pwr_state_seq;
  typedef struct packed {
    logic       rst_n;
    logic       drv;
    logic       d3;
    logic [1:0] wol;
    logic       cfg;
    logic [2:0] wt;
    logic [1:0] st;
    logic       hold;
    logic       clken;
    logic       idle;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,1'b1,2'b00,1'b1,3'd4,2'b00,1'b1,1'b1,1'b1},
    '{1'b0,1'b0,1'b0,2'b01,1'b0,3'd2,2'b00,1'b1,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,2'b10,1'b0,3'd1,2'b00,1'b1,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,2'b00,1'b0,3'd2,2'b00,1'b1,1'b0,1'b1},
    '{1'b1,1'b0,1'b0,2'b00,1'b0,3'd1,2'b01,1'b0,1'b1,1'b0},
    '{1'b1,1'b0,1'b1,2'b00,1'b0,3'd2,2'b01,1'b0,1'b1,1'b0},
    '{1'b1,1'b1,1'b0,2'b00,1'b0,3'd1,2'b10,1'b0,1'b1,1'b0},
    '{1'b1,1'b0,1'b0,2'b11,1'b0,3'd3,2'b10,1'b0,1'b1,1'b0},
    '{1'b1,1'b0,1'b1,2'b11,1'b0,3'd1,2'b11,1'b0,1'b1,1'b0},
    '{1'b1,1'b1,1'b0,2'b11,1'b0,3'd2,2'b11,1'b0,1'b1,1'b0},
    '{1'b0,1'b0,1'b0,2'b11,1'b0,3'd2,2'b11,1'b0,1'b1,1'b0},
    '{1'b0,1'b0,1'b0,2'b11,1'b1,3'd1,2'b00,1'b1,1'b1,1'b0},
    '{1'b0,1'b0,1'b0,2'b00,1'b1,3'd1,2'b00,1'b1,1'b1,1'b1},
    '{1'b1,1'b0,1'b0,2'b00,1'b0,3'd3,2'b01,1'b0,1'b1,1'b0},
    '{1'b1,1'b1,1'b0,2'b00,1'b0,3'd1,2'b10,1'b0,1'b1,1'b0},
    '{1'b0,1'b0,1'b0,2'b00,1'b0,3'd3,2'b00,1'b1,1'b0,1'b1}
  };

  logic       clk = 1'b0;
  logic       por;
  logic       rst_n;
  logic       drv;
  logic       d3;
  logic [1:0] wol;
  logic       cfg;
  logic [1:0] state;
  logic       idle;
  logic       clken;
  logic       hold;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pwr_state_seq u0 (
    .clk_i        (clk),
    .por_i        (por),
    .plat_rst_n_i (rst_n),
    .drv_init_i   (drv),
    .d3_req_i     (d3),
    .wake_act_i   (wol),
    .sb_clk_cfg_i (cfg),
    .state_o      (state),
    .deep_idle_o  (idle),
    .sb_clk_en_o  (clken),
    .wake_hold_o  (hold)
  );

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    por = 1'b1; rst_n = 1'b0; drv = 1'b0; d3 = 1'b0; wol = 2'b00; cfg = 1'b0;
    #1;
    chk("R1 state under power-on reset", state, 2'b00);
    chk("R1 hold under power-on reset", {1'b0, hold}, 2'b01);
    chk("R8 idle in reset without wake", {1'b0, idle}, 2'b01);
    step(2);
    por = 1'b0;

    for (int i = 0; i < NV; i++) begin
      rst_n = TBL[i].rst_n; drv = TBL[i].drv; d3 = TBL[i].d3;
      wol = TBL[i].wol; cfg = TBL[i].cfg;
      step(int'(TBL[i].wt));
      chk($sformatf("R2,R3,R4,R5 state vector %0d", i), state, TBL[i].st);
      chk($sformatf("R6 hold vector %0d", i), {1'b0, hold}, {1'b0, TBL[i].hold});
      chk($sformatf("R7 clock enable vector %0d", i), {1'b0, clken}, {1'b0, TBL[i].clken});
      chk($sformatf("R8 deep idle vector %0d", i), {1'b0, idle}, {1'b0, TBL[i].idle});
    end

    // R3: reset assertion from the uninitialized state, exact edge count
    rst_n = 1'b1; drv = 1'b0; d3 = 1'b0; wol = 2'b00; cfg = 1'b0;
    step(3);
    chk("R2 release again", state, 2'b01);
    rst_n = 1'b0;
    step(2);
    chk("R3 uninit before third edge", state, 2'b01);
    step(1);
    chk("R3 uninit to reset on third edge", state, 2'b00);

    // R4: long reset with drv_init and d3_req held high
    drv = 1'b1; d3 = 1'b1;
    step(200);
    chk("R4 long reset no timeout", state, 2'b00);
    drv = 1'b0; d3 = 1'b0;

    // R1: power-on reset acts asynchronously from the active state
    rst_n = 1'b1;
    step(3);
    drv = 1'b1;
    step(1);
    drv = 1'b0;
    chk("R5 active before power-on reset", state, 2'b10);
    #1 por = 1'b1;
    #0.5;
    chk("R1 asynchronous entry to reset", state, 2'b00);
    chk("R1 hold asynchronous", {1'b0, hold}, 2'b01);
    @(negedge clk);
    por = 1'b0;
    step(2);
    chk("R2 not yet left reset after por", state, 2'b00);
    step(1);
    chk("R2 leaves reset with line already high", state, 2'b01);

    finish_run();
  end
endmodule